// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block connects a single host request port to an asynchronous DRAM array made of rows and columns of multi-bit cells. Each host address is split so that the upper bits name a row and the lower bits name a column. The two indices share one narrow address bus to the array. A row strobe loads the whole row into the array's row buffer. A column strobe then selects one cell from that buffer, either to read it or to write it. Read data returns to the host with a one-cycle valid pulse.

The controller keeps the last row open. Another access to the same row needs only a column strobe. An access to a different row first spends one precharge cycle with both strobes low, and then strobes the new row. A free-running timer raises periodic refresh requests. A refresh waits until the current access has completed. It closes any open row and strobes one row with no column strobe. The refreshed row advances in round-robin order. The array model inside the block corrupts any row that goes unstrobed for longer than its retention window, so missing refreshes show up as bad read data.

Top module: `pmdram_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `dram_ras`, `dram_cas`, `rd_valid` and `rd_data` are all 0.
- R2: The host address splits as row = `req_addr[3:2]` and column = `req_addr[1:0]`. The row index is on `dram_addr` during every cycle in which `dram_ras` is high for an access. The column index and `dram_we` equal to the request's write flag are on the bus during the cycle in which `dram_cas` is high.
- R3: Any access that arrives with no row open gets exactly one row-strobe cycle, followed by one column-strobe cycle. Counting from the accepting clock edge, a write's column strobe is in cycle 2 and a read's `rd_valid` is in cycle 3.
- R4: An access to the row that is already open gets no row strobe and exactly one column strobe. The column strobe is in cycle 1, and a read's `rd_valid` is in cycle 2.
- R5: An access to a row other than the open one gets one cycle with both strobes low, then one row strobe, then one column strobe. A write's column strobe is in cycle 3, and a read's `rd_valid` is in cycle 4.
- R6: A read returns the value most recently written to that address.
- R7: A write never raises `rd_valid`.
- R8: Refresh strobes (`dram_ras` high with no access in progress) repeat with a spacing within REF_INTERVAL±8 cycles (64 by default).
- R9: Successive refresh strobes carry row indices 0,1,2,3,0,… on `dram_addr`, each one greater, modulo the row count, than the previous.
- R10: A pending refresh holds `req_ready` low. An access already accepted completes first. After a refresh no row is open, so the next access follows R3.
- R11: With the host idle for many retention windows, every stored cell still reads back its written value.
- R12: `rd_valid` is a single-cycle pulse for each read.
- R13: `dram_ras` and `dram_cas` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Cell address, row in the upper half |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse marking read data |
| rd_data | output | 8 | Read data |
| dram_ras | output | 1 | Row strobe to the array |
| dram_cas | output | 1 | Column strobe to the array |
| dram_we | output | 1 | Write enable qualifying the column strobe |
| dram_addr | output | 2 | Shared row/column index bus |

## Verification
The hardest situation to reach is a refresh request landing while a row is open and the host is still pushing accesses. In that case the refresh must wait, close the row, and turn what would have been a row hit into a closed-row access. The bench drives its access stream back to back over thousands of cycles, so refresh requests fall at every phase of an access. It watches for row strobes that occur outside its own accesses and uses them to mark its model of the open row as closed. It then predicts, from the ports alone, whether each access is a hit, a row change or a closed-row access, and checks the exact strobe counts and latency for that case. A long idle stretch followed by a full read-back confirms that the round-robin refresh keeps every row within its retention window.

// File: rtl/pmdram_pkg.sv
`timescale 1ns/1ps
package pmdram_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // no row open
        ST_OPEN,   // row open, waiting
        ST_ROW,    // row strobe cycle
        ST_COL,    // column strobe cycle
        ST_PRE,    // precharge: both strobes low, row closes
        ST_REF     // refresh row strobe
    } seq_state_e;
endpackage

// File: rtl/pmdram_refresh_timer.sv
`timescale 1ns/1ps
module pmdram_refresh_timer #(
    parameter int INTERVAL = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pend
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (q.cnt == LAST) begin
            d.cnt  = '0;
            d.pend = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
            if (ack) d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend = q.pend;

    // R8: a raised request stays raised until the sequencer takes it
    a_r8_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack) |=> pend);
endmodule

// File: rtl/pmdram_array.sv
`timescale 1ns/1ps
module pmdram_array #(
    parameter int ROW_W     = 2,
    parameter int COL_W     = 2,
    parameter int DATA_W    = 8,
    parameter int RETENTION = 512,
    localparam int BUS_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  addr,
    input  logic              ras,
    input  logic              cas,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int ROWS  = 1 << ROW_W;
    localparam int COLS  = 1 << COL_W;
    localparam int AGE_W = $clog2(RETENTION + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(RETENTION);

    logic [DATA_W-1:0] mem_d [ROWS][COLS];
    logic [DATA_W-1:0] mem_q [ROWS][COLS];
    logic [DATA_W-1:0] buf_d [COLS];
    logic [DATA_W-1:0] buf_q [COLS];
    logic [ROW_W-1:0]  brow_d, brow_q;
    logic [AGE_W-1:0]  age_d [ROWS];
    logic [AGE_W-1:0]  age_q [ROWS];
    logic              decay_any;

    logic [ROW_W-1:0] row_sel;
    logic [COL_W-1:0] col_sel;
    assign row_sel = addr[ROW_W-1:0];
    assign col_sel = addr[COL_W-1:0];

    always_comb begin
        mem_d     = mem_q;
        buf_d     = buf_q;
        brow_d    = brow_q;
        age_d     = age_q;
        decay_any = 1'b0;
        for (int r = 0; r < ROWS; r++) begin
            if (age_q[r] == AGE_MAX) begin
                decay_any = 1'b1;
            end else begin
                age_d[r] = age_q[r] + 1'b1;
                if (age_q[r] == AGE_MAX - 1'b1) begin
                    for (int c = 0; c < COLS; c++) mem_d[r][c] = ~mem_q[r][c];
                end
            end
        end
        if (ras) begin
            for (int c = 0; c < COLS; c++) buf_d[c] = mem_q[row_sel][c];
            brow_d         = row_sel;
            age_d[row_sel] = '0;
        end else if (cas && we) begin
            buf_d[col_sel]         = wdata;
            mem_d[brow_q][col_sel] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                age_q[r] <= '0;
                for (int c = 0; c < COLS; c++) mem_q[r][c] <= '0;
            end
            for (int c = 0; c < COLS; c++) buf_q[c] <= '0;
            brow_q <= '0;
        end else begin
            mem_q  <= mem_d;
            buf_q  <= buf_d;
            brow_q <= brow_d;
            age_q  <= age_d;
        end
    end

    assign rdata = cas ? buf_q[col_sel] : '0;

    // R11: no row ever outlives its retention window
    a_r11_no_decay: assert property (@(posedge clk) disable iff (!rst_n)
        !decay_any);
endmodule

// File: rtl/pmdram_seq.sv
`timescale 1ns/1ps
module pmdram_seq
    import pmdram_pkg::*;
#(
    parameter int ROW_W  = 2,
    parameter int COL_W  = 2,
    parameter int DATA_W = 8,
    localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int ADDR_W = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ref_pend,
    output logic              ref_ack,
    output logic [BUS_W-1:0]  dram_addr,
    output logic              dram_ras,
    output logic              dram_cas,
    output logic              dram_we,
    output logic [DATA_W-1:0] dram_wdata,
    input  logic [DATA_W-1:0] dram_rdata
);
    typedef struct packed {
        seq_state_e        state;
        logic              row_valid;
        logic [ROW_W-1:0]  open_row;
        logic              pend_req;
        logic [ROW_W-1:0]  lat_row;
        logic [COL_W-1:0]  lat_col;
        logic              lat_we;
        logic [DATA_W-1:0] lat_wdata;
        logic [ROW_W-1:0]  ref_row;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } seq_t;

    seq_t d, q;
    logic accept;

    assign req_ready = ((q.state == ST_IDLE) || (q.state == ST_OPEN)) && !ref_pend;
    assign accept    = req_valid && req_ready;

    always_comb begin
        d          = q;
        d.rd_valid = 1'b0;
        ref_ack    = 1'b0;
        if (accept) begin
            d.pend_req  = 1'b1;
            d.lat_row   = req_addr[ADDR_W-1:COL_W];
            d.lat_col   = req_addr[COL_W-1:0];
            d.lat_we    = req_we;
            d.lat_wdata = req_wdata;
        end
        unique case (q.state)
            ST_IDLE: begin
                if (ref_pend)    d.state = ST_REF;
                else if (accept) d.state = ST_ROW;
            end
            ST_OPEN: begin
                if (ref_pend) d.state = ST_PRE;
                else if (accept) begin
                    if (req_addr[ADDR_W-1:COL_W] == q.open_row) d.state = ST_COL;
                    else                                         d.state = ST_PRE;
                end
            end
            ST_PRE: begin
                d.row_valid = 1'b0;
                d.state     = q.pend_req ? ST_ROW : ST_REF;
            end
            ST_ROW: begin
                d.row_valid = 1'b1;
                d.open_row  = q.lat_row;
                d.state     = ST_COL;
            end
            ST_COL: begin
                d.pend_req = 1'b0;
                d.state    = ST_OPEN;
                if (!q.lat_we) begin
                    d.rd_valid = 1'b1;
                    d.rd_data  = dram_rdata;
                end
            end
            ST_REF: begin
                ref_ack   = 1'b1;
                d.ref_row = q.ref_row + 1'b1;
                d.state   = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        dram_ras   = (q.state == ST_ROW) || (q.state == ST_REF);
        dram_cas   = (q.state == ST_COL);
        dram_we    = (q.state == ST_COL) && q.lat_we;
        dram_wdata = q.lat_wdata;
        unique case (q.state)
            ST_ROW:  dram_addr = BUS_W'(q.lat_row);
            ST_COL:  dram_addr = BUS_W'(q.lat_col);
            ST_REF:  dram_addr = BUS_W'(q.ref_row);
            default: dram_addr = '0;
        endcase
    end

    assign rd_valid = q.rd_valid;
    assign rd_data  = q.rd_data;

    // R13: the two strobes never overlap
    a_r13_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dram_ras && dram_cas));
    // R4: a column strobe only ever lands on an open row
    a_r4_cas_on_open_row: assert property (@(posedge clk) disable iff (!rst_n)
        dram_cas |-> q.row_valid);
    // R12: read data valid lasts one cycle
    a_r12_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R10: pending refresh blocks new host requests
    a_r10_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend |-> !req_ready);
    // R9: each refresh moves on to the next row
    a_r9_ref_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_REF) |=> (q.ref_row == $past(q.ref_row) + 1'b1));
    // R5: precharge is followed by a row strobe
    a_r5_pre_then_ras: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_PRE) |=> (dram_ras && !dram_cas));
endmodule

// File: rtl/pmdram_ctrl.sv
`timescale 1ns/1ps
module pmdram_ctrl #(
    parameter int ROW_W        = 2,
    parameter int COL_W        = 2,
    parameter int DATA_W       = 8,
    parameter int REF_INTERVAL = 64,
    localparam int BUS_W       = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int ADDR_W      = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              dram_ras,
    output logic              dram_cas,
    output logic              dram_we,
    output logic [BUS_W-1:0]  dram_addr
);
    localparam int RETAIN = 2 * (1 << ROW_W) * REF_INTERVAL;

    logic              ref_pend;
    logic              ref_ack;
    logic [DATA_W-1:0] arr_wdata;
    logic [DATA_W-1:0] arr_rdata;

    pmdram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .ack  (ref_ack),
        .pend (ref_pend)
    );

    pmdram_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .ref_pend  (ref_pend),
        .ref_ack   (ref_ack),
        .dram_addr (dram_addr),
        .dram_ras  (dram_ras),
        .dram_cas  (dram_cas),
        .dram_we   (dram_we),
        .dram_wdata(arr_wdata),
        .dram_rdata(arr_rdata)
    );

    pmdram_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                   .RETENTION(RETAIN)) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (dram_addr),
        .ras  (dram_ras),
        .cas  (dram_cas),
        .we   (dram_we),
        .wdata(arr_wdata),
        .rdata(arr_rdata)
    );
endmodule

// File: tb/tb_pmdram_ctrl.sv
`timescale 1ns/1ps
module tb_pmdram_ctrl;
    localparam int ROWS     = 4;
    localparam int INTERVAL = 64;
    localparam int NVEC     = 24;

    // {we, addr[3:0], wdata[7:0]}
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b0, 4'd0,  8'h00}, {1'b0, 4'd1,  8'h00}, {1'b0, 4'd2,  8'h00}, {1'b0, 4'd3,  8'h00},
        {1'b0, 4'd0,  8'h00}, {1'b0, 4'd8,  8'h00}, {1'b0, 4'd0,  8'h00}, {1'b0, 4'd8,  8'h00},
        {1'b1, 4'd5,  8'hA1}, {1'b0, 4'd5,  8'h00}, {1'b0, 4'd4,  8'h00}, {1'b1, 4'd15, 8'h5E},
        {1'b1, 4'd14, 8'hC3}, {1'b0, 4'd14, 8'h00}, {1'b0, 4'd15, 8'h00}, {1'b0, 4'd12, 8'h00},
        {1'b0, 4'd3,  8'h00}, {1'b0, 4'd7,  8'h00}, {1'b0, 4'd11, 8'h00}, {1'b0, 4'd15, 8'h00},
        {1'b0, 4'd10, 8'h00}, {1'b0, 4'd10, 8'h00}, {1'b1, 4'd10, 8'h77}, {1'b0, 4'd10, 8'h00}
    };

    logic       clk, rst_n;
    logic       req_valid, req_ready, req_we;
    logic [3:0] req_addr;
    logic [7:0] req_wdata, rd_data;
    logic       rd_valid, dram_ras, dram_cas, dram_we;
    logic [1:0] dram_addr;

    pmdram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras(dram_ras),
        .dram_cas(dram_cas), .dram_we(dram_we), .dram_addr(dram_addr)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    logic [7:0] shadow [16];
    bit in_txn = 0, bench_open = 0;
    int bench_row = 0, cyc = 0, n_ref = 0, last_ref_row = -1, last_ref_cyc = -1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // refresh strobes: row strobes seen outside bench accesses
    always @(negedge clk) begin
        cyc++;
        if (rst_n && dram_ras && !in_txn) begin
            bench_open = 0;
            n_ref++;
            if (last_ref_row >= 0)
                check(int'(dram_addr) == (last_ref_row + 1) % ROWS, "R9",
                      "refresh row order", dram_addr, (last_ref_row + 1) % ROWS);
            if (last_ref_cyc >= 0)
                check((cyc - last_ref_cyc) >= INTERVAL - 8 && (cyc - last_ref_cyc) <= INTERVAL + 8,
                      "R8", "refresh spacing", cyc - last_ref_cyc, INTERVAL);
            last_ref_row = dram_addr;
            last_ref_cyc = cyc;
        end
    end

    task automatic do_access(input bit we, input int addr, input logic [7:0] wd,
                             input string dtag);
        int row = addr >> 2, col = addr & 3;
        int lat = 0, nras = 0, ncas = 0, exp_lat;
        bit waited = 0, hit, was_open, got = 0;
        logic [7:0] data = '0;
        string tag;
        @(negedge clk);
        while (!req_ready) begin waited = 1; @(negedge clk); end
        was_open = bench_open;
        hit      = bench_open && (bench_row == row);
        tag      = hit ? "R4" : (was_open ? "R5" : "R3");
        if (waited) tag = {tag, " R10"};
        req_valid = 1; req_we = we; req_addr = 4'(addr); req_wdata = wd; in_txn = 1;
        @(negedge clk);
        req_valid = 0;
        forever begin
            lat++;
            if (lat == 1 && was_open && !hit)
                check(!dram_ras && !dram_cas, "R5", "precharge cycle strobes", {dram_ras, dram_cas}, 0);
            if (dram_ras) begin
                nras++;
                check(int'(dram_addr) == row, "R2", "row index on bus", dram_addr, row);
            end
            if (dram_cas) begin
                ncas++;
                check(int'(dram_addr) == col, "R2", "column index on bus", dram_addr, col);
                check(dram_we == we, "R2", "write flag with column strobe", dram_we, we);
            end
            if (we) begin
                check(!rd_valid, "R7", "rd_valid during write", rd_valid, 0);
                if (ncas == 1) break;
            end else if (rd_valid) begin
                got = 1; data = rd_data; break;
            end
            if (lat > 8) break;
            @(negedge clk);
        end
        exp_lat = (hit ? 1 : (was_open ? 3 : 2)) + (we ? 0 : 1);
        check(lat == exp_lat, tag, "latency", lat, exp_lat);
        check(nras == (hit ? 0 : 1), tag, "row strobe count", nras, hit ? 0 : 1);
        check(ncas == 1, tag, "column strobe count", ncas, 1);
        if (!we) begin
            check(got && data == shadow[addr], dtag, "read data", data, shadow[addr]);
            @(negedge clk);
            check(!rd_valid, "R12", "rd_valid pulse width", rd_valid, 0);
        end else begin
            shadow[addr] = wd;
        end
        in_txn = 0;
        bench_open = 1;
        bench_row = row;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: run hung, actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0;
        for (int i = 0; i < 16; i++) shadow[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(req_ready == 1, "R1", "ready after reset", req_ready, 1);
        check(!dram_ras && !dram_cas, "R1", "strobes after reset", {dram_ras, dram_cas}, 0);
        check(!rd_valid && rd_data == 0, "R1", "read outputs after reset", rd_data, 0);

        for (int i = 0; i < 16; i++) do_access(1'b1, i, 8'(i * 29 + 7), "R6");
        for (int i = 0; i < NVEC; i++)
            do_access(VEC[i][12], int'(VEC[i][11:8]), VEC[i][7:0], "R6");
        // sustained back-to-back traffic so refresh lands at every phase
        for (int k = 0; k < 40; k++) begin
            do_access(1'b0, (k % 2 == 0) ? 1 : 9, 8'h00, "R6");
            do_access(1'b0, 2 + ((k / 3) % 2) * 4, 8'h00, "R6");
        end
        // long idle, then full read-back
        repeat (2048) @(negedge clk);
        for (int i = 0; i < 16; i++) do_access(1'b0, i, 8'h00, "R11");
        check(n_ref >= 30, "R8", "refresh strobe count", n_ref, 30);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule